// File: doc/BRIEF.md
# SPI Wiper Register Controller

This block is the digital control core of a single-channel digitally controlled potentiometer. A 10-bit volatile wiper register chooses one of 1024 taps along a string of 1023 resistive elements. The block drives that choice out both as a binary code and as a one-hot tap-select vector. A bank of four data registers stands in for nonvolatile storage. It is held in flops that no reset clears, so several wiper positions survive a reset. A write into the bank opens a timed busy window.

A host talks to the block over an SPI slave port in mode 0, framed by an active-low chip select. Each frame carries an instruction byte and then a 16-bit data word. The host can write or read the wiper register and write or read any data register. It can also copy a data register into the wiper register, or the wiper register into a data register. When reset is released, the wiper register already holds the contents of data register 0, so the restored position is in place before the first command arrives.

Top module: `dpot_ctrl`

## Requirements
- R1: While reset is high, the wiper register loads data register 0, so `wiper_code` equals that register from the first cycle after reset. Data register 0 holds DEFAULT_POS (512) at power-up and the other registers hold 0. Reset changes none of the data registers.
- R2: A frame starts when `spi_cs_n` goes low and is sampled on rising `spi_sclk`, MSB first. It is 24 bits: an instruction byte (opcode in bits 7:4, register index in bits 1:0) and then a 16-bit data word, of which only bits 9:0 are used. The command acts after the 24th rising edge.
- R3: Opcode 0x1 writes data bits 9:0 into the wiper register.
- R4: Opcode 0x2 reads the wiper register. During the 16 data bits, MISO returns the word {busy, 5'b0, value}, MSB first. Bit 15 is driven after the 8th rising edge, and later bits change after falling edges.
- R5: Opcode 0x3 writes data bits 9:0 into the data register selected by the index.
- R6: Opcode 0x4 reads the indexed data register, in the same word format as R4.
- R7: Opcode 0x5 copies the indexed data register into the wiper register.
- R8: Opcode 0x6 copies the wiper register into the indexed data register.
- R9: An accepted write to the bank (opcode 0x3 or 0x6) makes the flag busy for BUSY_CYCLES clocks. While busy, further writes to the bank are ignored. Bit 15 of every read word reports the flag as it stood when the instruction byte completed.
- R10: If chip select rises before the 24th bit, the frame is dropped and no register changes.
- R11: `tap_sel` always has exactly one bit set, at the index given by `wiper_code`.
- R12: Opcodes other than 0x1 to 0x6 change no register. Their read word carries only the busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 while not selected |
| wiper_code | output | 10 | Current wiper position, binary |
| tap_sel | output | 1024 | One-hot tap switch select |

## Verification
A wrong wiper register shows within one clock on both `wiper_code` and the one-hot `tap_sel`. The bench compares these against its own model after every frame. A wrong data register or a wrong busy flag stays hidden until the next read frame, where it appears in the MISO word. For that reason each write to the bank is followed, later in the run, by a read of that register, and the busy bit is checked both inside and after its window. A reset pulse followed by reads shows whether the bank wrongly follows reset and whether the wiper reload is wrong.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int INSTR_W = 8;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = INSTR_W + WORD_W;
    localparam int OPC_W   = 4;
    localparam int SEL_W   = 2;
    localparam int PAD_W   = INSTR_W - OPC_W - SEL_W;

    typedef enum logic [OPC_W-1:0] {
        OP_WR_WCR    = 4'h1,
        OP_RD_WCR    = 4'h2,
        OP_WR_DR     = 4'h3,
        OP_RD_DR     = 4'h4,
        OP_DR_TO_WCR = 4'h5,
        OP_WCR_TO_DR = 4'h6
    } opcode_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [PAD_W-1:0] pad;
        logic [SEL_W-1:0] sel;
    } instr_t;

    typedef struct packed {
        instr_t            ins;
        logic [WORD_W-1:0] data;
    } frame_t;

    function automatic logic writes_bank(input logic [OPC_W-1:0] opc);
        return (opc == OP_WR_DR) || (opc == OP_WCR_TO_DR);
    endfunction

    function automatic logic reads_reg(input logic [OPC_W-1:0] opc);
        return (opc == OP_RD_WCR) || (opc == OP_RD_DR);
    endfunction

endpackage

// File: rtl/dpot_spi_rx.sv
module dpot_spi_rx
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [WORD_W-1:0] tx_word,
    output instr_t            hdr,
    output frame_t            cmd,
    output logic              cmd_valid,
    output logic              spi_miso
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] HDR_DONE   = CNT_W'(INSTR_W);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_W);

    logic [2:0]         sclk_sr;
    logic [1:0]         cs_sr;
    logic [1:0]         mosi_sr;
    logic               sclk_rise;
    logic               sclk_fall;
    logic               selected;
    logic               mosi_s;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [WORD_W-1:0]  tx_q;

    // two-stage synchronisers plus one edge-detect stage for the clock
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
        end else begin
            sclk_sr <= {sclk_sr[1:0], spi_sclk};
            cs_sr   <= {cs_sr[0], spi_cs_n};
            mosi_sr <= {mosi_sr[0], spi_mosi};
        end
    end

    assign sclk_rise = sclk_sr[1] & ~sclk_sr[2];
    assign sclk_fall = ~sclk_sr[1] & sclk_sr[2];
    assign selected  = ~cs_sr[1];
    assign mosi_s    = mosi_sr[1];

    // instruction byte as it stands on the edge that completes it
    assign hdr = instr_t'({shreg[INSTR_W-2:0], mosi_s});

    always_ff @(posedge clk) begin
        if (rst || !selected) begin
            bit_cnt   <= '0;
            tx_q      <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (sclk_rise && bit_cnt < FRAME_END) begin
                shreg   <= {shreg[FRAME_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == HDR_LAST) begin
                    tx_q <= tx_word;
                end
                if (bit_cnt == FRAME_LAST) begin
                    cmd_valid <= 1'b1;
                end
            end else if (sclk_fall && bit_cnt > HDR_DONE && bit_cnt < FRAME_END) begin
                tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign cmd      = frame_t'(shreg);
    assign spi_miso = selected & tx_q[WORD_W-1];

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
    import dpot_pkg::*;
#(
    parameter int WIPER_W     = 10,
    parameter int NUM_DR      = 4,
    parameter int BUSY_CYCLES = 8000,
    parameter int DEFAULT_POS = 512
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cmd_valid,
    input  frame_t                           cmd,
    input  instr_t                           hdr,
    output logic [WIPER_W-1:0]               wiper,
    output logic [NUM_DR-1:0][WIPER_W-1:0]   nv_bank,
    output logic                             busy,
    output logic [WORD_W-1:0]                rd_word
);

    localparam int IDX_W  = $clog2(NUM_DR);
    localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [BCNT_W-1:0] BUSY_LOAD = BCNT_W'(BUSY_CYCLES);

    logic [NUM_DR-1:0][WIPER_W-1:0] nv_q;
    logic [WIPER_W-1:0]             wcr_q;
    logic [BCNT_W-1:0]              bcnt_q;
    logic [IDX_W-1:0]               cmd_idx;
    logic [IDX_W-1:0]               hdr_idx;
    logic                           bank_wr;
    logic [WIPER_W-1:0]             bank_wdata;
    logic [WIPER_W-1:0]             rd_val;

    assign cmd_idx = cmd.ins.sel[IDX_W-1:0];
    assign hdr_idx = hdr.sel[IDX_W-1:0];
    assign busy    = (bcnt_q != '0);
    assign bank_wr = cmd_valid && !rst && !busy && writes_bank(cmd.ins.opc);
    assign bank_wdata = (cmd.ins.opc == OP_WR_DR) ? cmd.data[WIPER_W-1:0] : wcr_q;

    // stored image at power-up; reset never touches the bank afterwards
    initial begin
        for (int i = 0; i < NUM_DR; i++) begin
            nv_q[i] <= (i == 0) ? WIPER_W'(DEFAULT_POS) : '0;
        end
    end

    always @(posedge clk) begin
        if (bank_wr) begin
            nv_q[cmd_idx] <= bank_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcr_q  <= nv_q[0];
            bcnt_q <= '0;
        end else begin
            if (bank_wr) begin
                bcnt_q <= BUSY_LOAD;
            end else if (busy) begin
                bcnt_q <= bcnt_q - 1'b1;
            end
            if (cmd_valid) begin
                case (cmd.ins.opc)
                    OP_WR_WCR:    wcr_q <= cmd.data[WIPER_W-1:0];
                    OP_DR_TO_WCR: wcr_q <= nv_q[cmd_idx];
                    default:      ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (hdr.opc)
            OP_RD_WCR: rd_val = wcr_q;
            OP_RD_DR:  rd_val = nv_q[hdr_idx];
            default:   rd_val = '0;
        endcase
        rd_word              = '0;
        rd_word[WORD_W-1]    = busy;
        rd_word[WIPER_W-1:0] = reads_reg(hdr.opc) ? rd_val : '0;
    end

    assign wiper   = wcr_q;
    assign nv_bank = nv_q;

endmodule

// File: rtl/dpot_tap_dec.sv
module dpot_tap_dec #(
    parameter int WIPER_W = 10
) (
    input  logic [WIPER_W-1:0]         code,
    output logic [(1<<WIPER_W)-1:0]    onehot
);

    localparam int TAPS = 1 << WIPER_W;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign onehot[i] = (code == WIPER_W'(i));
    end

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int WIPER_W     = 10,
    parameter int NUM_DR      = 4,
    parameter int BUSY_CYCLES = 8000,
    parameter int DEFAULT_POS = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      spi_sclk,
    input  logic                      spi_cs_n,
    input  logic                      spi_mosi,
    output logic                      spi_miso,
    output logic [WIPER_W-1:0]        wiper_code,
    output logic [(1<<WIPER_W)-1:0]   tap_sel
);

    instr_t                         hdr;
    frame_t                         cmd;
    logic                           cmd_valid;
    logic [WORD_W-1:0]              rd_word;
    logic                           busy;
    logic [NUM_DR-1:0][WIPER_W-1:0] nv_bank;

    dpot_spi_rx u_spi (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .tx_word   (rd_word),
        .hdr       (hdr),
        .cmd       (cmd),
        .cmd_valid (cmd_valid),
        .spi_miso  (spi_miso)
    );

    dpot_regs #(
        .WIPER_W     (WIPER_W),
        .NUM_DR      (NUM_DR),
        .BUSY_CYCLES (BUSY_CYCLES),
        .DEFAULT_POS (DEFAULT_POS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .hdr       (hdr),
        .wiper     (wiper_code),
        .nv_bank   (nv_bank),
        .busy      (busy),
        .rd_word   (rd_word)
    );

    dpot_tap_dec #(
        .WIPER_W (WIPER_W)
    ) u_dec (
        .code   (wiper_code),
        .onehot (tap_sel)
    );

endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk
    import dpot_pkg::*;
#(
    parameter int WIPER_W = 10,
    parameter int NUM_DR  = 4
) (
    input logic                             clk,
    input logic                             rst,
    input logic [WIPER_W-1:0]               wiper_code,
    input logic [(1<<WIPER_W)-1:0]          tap_sel,
    input logic                             busy,
    input logic [NUM_DR-1:0][WIPER_W-1:0]   nv_bank,
    input logic                             cmd_valid,
    input logic [OPC_W-1:0]                 cmd_opc
);

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1); // R11

    AST_TAP_MATCH: assert property (@(posedge clk) disable iff (rst)
        tap_sel[wiper_code]); // R11

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> wiper_code == nv_bank[0]); // R1

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(nv_bank)); // R9

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && (cmd_opc == OP_WR_DR || cmd_opc == OP_WCR_TO_DR)) |=> busy); // R9

    AST_WIPER_ONLY_CMD: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper_code) |-> ($past(cmd_valid) || $past(rst))); // R10

endmodule

bind dpot_ctrl dpot_ctrl_chk #(
    .WIPER_W (WIPER_W),
    .NUM_DR  (NUM_DR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wiper_code (wiper_code),
    .tap_sel    (tap_sel),
    .busy       (busy),
    .nv_bank    (nv_bank),
    .cmd_valid  (cmd_valid),
    .cmd_opc    (cmd.ins.opc)
);

// File: tb/tb_dpot_ctrl.sv
module tb_dpot_ctrl;

    localparam int W     = 10;
    localparam int BUSY  = 8000;
    localparam int HALF  = 200;   // SPI half period: 50 clocks of 4 units
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [7:0]   ins;
        logic [15:0]  dat;
        logic [W-1:0] exp_w;
        logic [15:0]  exp_rd;
        logic         wait_nv;
    } vec_t;

    // instr, data, expected wiper, expected read word, wait for busy to clear
    localparam vec_t VECS [NVEC] = '{
        '{8'h20, 16'h0000, 10'h200, 16'h0200, 1'b0},  // R4 read wiper after reset
        '{8'h10, 16'hFC5A, 10'h05A, 16'h0000, 1'b0},  // R2 R3 upper data bits dropped
        '{8'h32, 16'h03FF, 10'h05A, 16'h0000, 1'b1},  // R5 write reg 2
        '{8'h42, 16'h0000, 10'h05A, 16'h03FF, 1'b0},  // R6 read reg 2
        '{8'h52, 16'h0000, 10'h3FF, 16'h0000, 1'b0},  // R7 reg 2 to wiper
        '{8'h10, 16'h0001, 10'h001, 16'h0000, 1'b0},  // R3 low code
        '{8'h61, 16'h0000, 10'h001, 16'h0000, 1'b1},  // R8 wiper to reg 1
        '{8'h41, 16'h0000, 10'h001, 16'h0001, 1'b0},  // R8 R6 read reg 1
        '{8'h50, 16'h0000, 10'h200, 16'h0000, 1'b0},  // R7 reg 0 to wiper
        '{8'h43, 16'h0000, 10'h200, 16'h0000, 1'b0},  // R6 reg 3 power-up zero
        '{8'h70, 16'h0123, 10'h200, 16'h0000, 1'b0},  // R12 unknown opcode
        '{8'h10, 16'h03FF, 10'h3FF, 16'h0000, 1'b0}   // R3 top code
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            spi_sclk = 1'b0;
    logic            spi_cs_n = 1'b1;
    logic            spi_mosi = 1'b0;
    logic            spi_miso;
    logic [W-1:0]    wiper_code;
    logic [(1<<W)-1:0] tap_sel;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    logic [15:0] rd;

    always #2 clk = ~clk;

    dpot_ctrl #(.BUSY_CYCLES(BUSY)) dut (
        .clk        (clk),
        .rst        (rst),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .wiper_code (wiper_code),
        .tap_sel    (tap_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_tap(input string req, input logic [W-1:0] exp);
        chk({req, " tap count"}, 32'($countones(tap_sel)), 32'd1);
        chk({req, " tap bit"}, {31'd0, tap_sel[exp]}, 32'd1);
    endtask

    task automatic spi_frame(input logic [7:0] ins, input logic [15:0] dat,
                             input int nbits, output logic [15:0] rdw);
        logic [23:0] word;
        word = {ins, dat};
        rdw  = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = word[23-i];
            #(HALF);
            spi_sclk = 1'b1;
            if (i >= 8) rdw[23-i] = spi_miso;
            #(HALF);
            spi_sclk = 1'b0;
        end
        #(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R1 wiper after power-up reset", 32'(wiper_code), 32'h200);
        chk_tap("R11 reset", 10'h200);
        chk("R4 miso idle", {31'd0, spi_miso}, 32'd0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            spi_frame(VECS[v].ins, VECS[v].dat, 24, rd);
            chk($sformatf("vector %0d wiper", v), 32'(wiper_code), 32'(VECS[v].exp_w));
            chk($sformatf("vector %0d read word", v), 32'(rd), 32'(VECS[v].exp_rd));
            chk_tap($sformatf("R11 vector %0d", v), VECS[v].exp_w);
            if (VECS[v].wait_nv) repeat (BUSY + 100) @(negedge clk);
        end

        // busy window: second bank write ignored, flag visible
        spi_frame(8'h33, 16'h0155, 24, rd);
        spi_frame(8'h33, 16'h02AA, 24, rd);
        spi_frame(8'h43, 16'h0000, 24, rd);
        chk("R9 read during busy", 32'(rd), 32'h8155);
        repeat (BUSY + 100) @(negedge clk);
        spi_frame(8'h43, 16'h0000, 24, rd);
        chk("R9 busy cleared, write ignored", 32'(rd), 32'h0155);

        // abandoned frames
        spi_frame(8'h10, 16'h0077, 12, rd);
        chk("R10 abandon at 12 bits", 32'(wiper_code), 32'h3FF);
        spi_frame(8'h10, 16'h0077, 23, rd);
        chk("R10 abandon at 23 bits", 32'(wiper_code), 32'h3FF);
        spi_frame(8'h20, 16'h0000, 24, rd);
        chk("R10 R4 read after abandon", 32'(rd), 32'h03FF);

        // persistence across reset
        spi_frame(8'h30, 16'h00AB, 24, rd);
        repeat (BUSY + 100) @(negedge clk);
        spi_frame(8'h10, 16'h0111, 24, rd);
        chk("R3 wiper before reset", 32'(wiper_code), 32'h111);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wiper reload from reg 0", 32'(wiper_code), 32'h0AB);
        chk_tap("R11 after reload", 10'h0AB);
        spi_frame(8'h43, 16'h0000, 24, rd);
        chk("R1 reg 3 kept through reset", 32'(rd), 32'h0155);
        spi_frame(8'h42, 16'h0000, 24, rd);
        chk("R1 reg 2 kept through reset", 32'(rd), 32'h03FF);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule